// File: doc/BRIEF.md
# In-Order Word-State Check Unit with Pending-Update Forwarding

This unit sits in the back end of a processor, between the stage that requests per-word monitoring state and the commit stage. Every cycle it is offered a group of up to four memory events in program order. Each event carries an already resolved word address and an event code, plus the state cache's answer for that word (a hit flag and a state value). For each event the unit selects the freshest known state and hands the (state, event) pair to an external transition table. The table answers with a next state and an exception flag.

The freshest state comes from one of three sources, in this priority: an earlier event of the same group that targets the same word, the youngest matching entry of a small queue of uncommitted state updates, and the state cache response. If an event has no state from any source, the whole group waits. An exception flushes the excepting event and every younger event of its group. An event whose next state differs from its current state becomes a queue entry. Queue entries leave in order when commit retires them, and each one then becomes a write to the state cache. The queue pushes back when a group would overflow it.

Top module: `stchk_unit`

## Requirements
- R1: After reset the pending-update queue is empty: no write is presented whatever `commitNum` is, and no event can take its state from the queue.
- R2: A valid event with no earlier same-word event in its group and no matching queue entry presents `cacheState` as its current state on `tblCurState`, provided `cacheHit` is set for its lane.
- R3: If a valid event, reached before any exception in lane order, has no state from any source, then `stallMiss` is 1 and `grpReady` is 0. No exception is reported and nothing is queued. The same group presented again later, with its state available, is accepted.
- R4: A valid event whose address exactly equals the address of a queued entry takes that entry's state, whatever the cache says and whether or not it hits.
- R5: When several queued entries match, the youngest one supplies the state.
- R6: Within a group, a later event takes the table's next state from the latest earlier valid event that targets the same word.
- R7: The first valid lane, in lane order, whose table answer has the exception flag set raises `excValid` with `excLane` equal to its lane index. Earlier events of the group are still queued. The excepting event and all later events are not queued.
- R8: Only an accepted, non-flushed event whose next state differs from its current state adds a queue entry, and hence a later state write.
- R9: Each cycle the oldest min(`commitNum`, occupancy, 4) entries retire in age order. Write slot 0 carries the oldest entry, and `wrValid` is always a contiguous run starting at bit 0.
- R10: When occupancy plus the number of entries a group would add exceeds the queue depth of 8, `stallFull` is 1, `grpReady` is 0 and nothing is queued. A group that adds nothing is accepted even when the queue is full.
- R11: Lanes with `laneValid` clear have no effect: they do not stall, do not except, queue nothing and do not feed same-group forwarding.

Lane i occupies bits [i*W +: W] of every packed per-lane port, where W is the field width. Lane 0 is the oldest event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneValid | input | 4 | Event present in lane |
| laneAddr | input | 64 | Resolved word address per lane (16 bits each) |
| laneEvent | input | 24 | Event code per lane (6 bits each) |
| cacheHit | input | 4 | State cache answered for the lane |
| cacheState | input | 16 | State from the cache per lane (4 bits each) |
| tblCurState | output | 16 | Selected current state per lane, to the transition table |
| tblEvent | output | 24 | Event code per lane, to the transition table |
| tblNextState | input | 16 | Next state per lane, from the transition table |
| tblExc | input | 4 | Exception flag per lane, from the transition table |
| grpReady | output | 1 | Group is accepted this cycle |
| stallMiss | output | 1 | Group held: an event has no state |
| stallFull | output | 1 | Group held: queue would overflow |
| excValid | output | 1 | An accepted group contains an excepting event |
| excLane | output | 2 | Lane index of the excepting event |
| commitNum | input | 3 | Number of queue entries commit retires this cycle |
| wrValid | output | 4 | State write slot valid |
| wrAddr | output | 64 | Write address per slot (16 bits each) |
| wrState | output | 16 | Write state per slot (4 bits each) |

## Verification
The transition table in the bench follows a heap-tracking rule set, so every current state the unit selects can be seen in the next state and the exception it causes. The group patterns are chosen to tell the state sources apart: a stale cache value against a queued entry, two queued entries for one word, and an earlier same-group event against both. Other groups put the first missing state before or after an exception, fill the queue to one entry short, exactly full and one over, and retire with `commitNum` below, equal to and above the occupancy. A reset in the middle of a run then shows that queued entries neither forward nor reach the cache.

// File: rtl/stchk_pkg.sv
package stchk_pkg;
  localparam int unsigned Lanes    = 4;
  localparam int unsigned Depth    = 8;
  localparam int unsigned AddrW    = 16;
  localparam int unsigned StateW   = 4;
  localparam int unsigned EventW   = 6;
  localparam int unsigned LaneIdxW = (Lanes > 1) ? $clog2(Lanes) : 1;
  localparam int unsigned PtrW     = $clog2(Depth);
  localparam int unsigned CntW     = $clog2(Depth + 1);
  localparam int unsigned PopW     = $clog2(Lanes + 1);

  typedef struct packed {
    logic [Lanes-1:0] push;
    logic [PopW-1:0]  popNum;
  } qStrobe_t;

  typedef struct packed {
    logic [AddrW-1:0]  addr;
    logic [StateW-1:0] state;
  } qEntry_t;
endpackage

// File: rtl/stchk_fwdq.sv
module stchk_fwdq
  import stchk_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  qStrobe_t                      strobe,
  input  logic [Lanes-1:0][AddrW-1:0]   laneAddr,
  input  logic [Lanes-1:0][StateW-1:0]  newState,
  output logic [CntW-1:0]               qCount,
  output logic [Lanes-1:0]              fwdHit,
  output logic [Lanes-1:0][StateW-1:0]  fwdState,
  output logic [Lanes-1:0]              wrValid,
  output logic [Lanes-1:0][AddrW-1:0]   wrAddr,
  output logic [Lanes-1:0][StateW-1:0]  wrState
);
  qEntry_t            mem [Depth];
  logic [PtrW-1:0]    headPtr;
  logic [CntW-1:0]    count;
  logic [PtrW-1:0]    tailPtr;
  logic [Lanes-1:0][PtrW-1:0] pushOfs;
  logic [CntW-1:0]    pushCnt;

  assign qCount  = count;
  assign tailPtr = headPtr + count[PtrW-1:0];

  // Compact pushed lanes onto consecutive slots after the tail.
  always_comb begin
    logic [CntW-1:0] run;
    run = '0;
    for (int i = 0; i < Lanes; i++) begin
      pushOfs[i] = run[PtrW-1:0];
      if (strobe.push[i]) run = run + CntW'(1);
    end
    pushCnt = run;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < Lanes; i++) begin
      if (strobe.push[i]) begin
        mem[tailPtr + pushOfs[i]] <= '{addr: laneAddr[i], state: newState[i]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      count   <= '0;
    end else begin
      headPtr <= headPtr + PtrW'(strobe.popNum);
      count   <= count + pushCnt - CntW'(strobe.popNum);
    end
  end

  // Youngest-wins exact-address lookup: scan oldest to youngest, last match kept.
  always_comb begin
    for (int i = 0; i < Lanes; i++) begin
      fwdHit[i]   = 1'b0;
      fwdState[i] = '0;
      for (int k = 0; k < Depth; k++) begin
        if ((CntW'(k) < count) && (mem[headPtr + PtrW'(k)].addr == laneAddr[i])) begin
          fwdHit[i]   = 1'b1;
          fwdState[i] = mem[headPtr + PtrW'(k)].state;
        end
      end
    end
  end

  // Retire slots: slot k carries the k-th oldest entry.
  always_comb begin
    for (int k = 0; k < Lanes; k++) begin
      wrValid[k] = (CntW'(k) < CntW'(strobe.popNum));
      wrAddr[k]  = mem[headPtr + PtrW'(k)].addr;
      wrState[k] = mem[headPtr + PtrW'(k)].state;
    end
  end

  // R10
  count_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(count) <= Depth);

  // R9
  wr_prefix_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid & (wrValid + Lanes'(1))) == '0);

  // R8
  growth_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(count) <= 32'($past(count)) + Lanes);
endmodule

// File: rtl/stchk_ctrl.sv
module stchk_ctrl
  import stchk_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [Lanes-1:0]              laneValid,
  input  logic [Lanes-1:0][AddrW-1:0]   laneAddr,
  input  logic [Lanes-1:0]              cacheHit,
  input  logic [Lanes-1:0][StateW-1:0]  cacheState,
  input  logic [Lanes-1:0]              fwdHit,
  input  logic [Lanes-1:0][StateW-1:0]  fwdState,
  input  logic [Lanes-1:0][StateW-1:0]  tblNext,
  input  logic [Lanes-1:0]              tblExc,
  input  logic [CntW-1:0]               qCount,
  input  logic [PopW-1:0]               commitNum,
  output logic [Lanes-1:0][StateW-1:0]  curState,
  output logic                          grpReady,
  output logic                          stallMiss,
  output logic                          stallFull,
  output logic                          excValid,
  output logic [LaneIdxW-1:0]           excLane,
  output qStrobe_t                      strobe
);
  logic [Lanes-1:0]             have;
  logic [Lanes-1:0]             grpHit;
  logic [Lanes-1:0][StateW-1:0] grpSt;
  logic [Lanes-1:0]             pushRaw;
  logic                         missAny;
  logic                         excAny;
  logic [LaneIdxW-1:0]          excIdx;
  logic [CntW-1:0]              pushTotal;
  logic [CntW:0]                need;
  logic                         overFull;

  // State source per lane: earlier same-word lane, then queue, then cache.
  always_comb begin
    for (int i = 0; i < Lanes; i++) begin
      grpHit[i] = 1'b0;
      grpSt[i]  = '0;
      for (int j = 0; j < i; j++) begin
        if (laneValid[j] && (laneAddr[j] == laneAddr[i])) begin
          grpHit[i] = 1'b1;
          grpSt[i]  = tblNext[j];
        end
      end
      if (grpHit[i]) begin
        have[i] = 1'b1; curState[i] = grpSt[i];
      end else if (fwdHit[i]) begin
        have[i] = 1'b1; curState[i] = fwdState[i];
      end else if (cacheHit[i]) begin
        have[i] = 1'b1; curState[i] = cacheState[i];
      end else begin
        have[i] = 1'b0; curState[i] = '0;
      end
    end
  end

  // In-order walk: stop at the first missing state or the first exception.
  always_comb begin
    logic alive;
    alive   = 1'b1;
    missAny = 1'b0;
    excAny  = 1'b0;
    excIdx  = '0;
    pushRaw = '0;
    for (int i = 0; i < Lanes; i++) begin
      if (alive && laneValid[i]) begin
        if (!have[i]) begin
          missAny = 1'b1;
          alive   = 1'b0;
        end else if (tblExc[i]) begin
          excAny = 1'b1;
          excIdx = LaneIdxW'(i);
          alive  = 1'b0;
        end else if (tblNext[i] != curState[i]) begin
          pushRaw[i] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    pushTotal = '0;
    for (int i = 0; i < Lanes; i++) begin
      pushTotal = pushTotal + CntW'(pushRaw[i]);
    end
  end

  assign need      = {1'b0, qCount} + {1'b0, pushTotal};
  assign overFull  = (need > (CntW+1)'(Depth));
  assign stallMiss = missAny;
  assign stallFull = !missAny && overFull;
  assign grpReady  = !missAny && !overFull;
  assign excValid  = grpReady && excAny;
  assign excLane   = excIdx;

  always_comb begin
    int unsigned p;
    p = 32'(commitNum);
    if (p > 32'(qCount)) p = 32'(qCount);
    if (p > Lanes) p = Lanes;
    strobe.popNum = PopW'(p);
    strobe.push   = grpReady ? pushRaw : '0;
  end

  // R9
  pop_avail_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(strobe.popNum) <= 32'(qCount));

  // R10
  full_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallFull |-> (32'(qCount) + Lanes > Depth));

  // R3
  stall_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stallMiss, stallFull, excValid}));
endmodule

// File: rtl/stchk_unit.sv
module stchk_unit
  import stchk_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [Lanes-1:0]            laneValid,
  input  logic [Lanes*AddrW-1:0]      laneAddr,
  input  logic [Lanes*EventW-1:0]     laneEvent,
  input  logic [Lanes-1:0]            cacheHit,
  input  logic [Lanes*StateW-1:0]     cacheState,
  output logic [Lanes*StateW-1:0]     tblCurState,
  output logic [Lanes*EventW-1:0]     tblEvent,
  input  logic [Lanes*StateW-1:0]     tblNextState,
  input  logic [Lanes-1:0]            tblExc,
  output logic                        grpReady,
  output logic                        stallMiss,
  output logic                        stallFull,
  output logic                        excValid,
  output logic [LaneIdxW-1:0]         excLane,
  input  logic [PopW-1:0]             commitNum,
  output logic [Lanes-1:0]            wrValid,
  output logic [Lanes*AddrW-1:0]      wrAddr,
  output logic [Lanes*StateW-1:0]     wrState
);
  logic [Lanes-1:0][AddrW-1:0]  addrV;
  logic [Lanes-1:0][StateW-1:0] cacheV;
  logic [Lanes-1:0][StateW-1:0] nextV;
  logic [Lanes-1:0][StateW-1:0] curV;
  logic [Lanes-1:0]             fwdHit;
  logic [Lanes-1:0][StateW-1:0] fwdState;
  logic [Lanes-1:0][AddrW-1:0]  wrAddrV;
  logic [Lanes-1:0][StateW-1:0] wrStateV;
  logic [CntW-1:0]              qCount;
  qStrobe_t                     strobe;

  assign addrV       = laneAddr;
  assign cacheV      = cacheState;
  assign nextV       = tblNextState;
  assign tblCurState = curV;
  assign tblEvent    = laneEvent;
  assign wrAddr      = wrAddrV;
  assign wrState     = wrStateV;

  stchk_ctrl ctrl_i (
    .clk, .rstN, .laneValid, .laneAddr(addrV), .cacheHit, .cacheState(cacheV),
    .fwdHit, .fwdState, .tblNext(nextV), .tblExc, .qCount, .commitNum,
    .curState(curV), .grpReady, .stallMiss, .stallFull, .excValid, .excLane,
    .strobe
  );

  stchk_fwdq fwdq_i (
    .clk, .rstN, .strobe, .laneAddr(addrV), .newState(nextV), .qCount,
    .fwdHit, .fwdState, .wrValid, .wrAddr(wrAddrV), .wrState(wrStateV)
  );
endmodule

// File: tb/stchk_unit_tb.sv
module stchk_unit_tb_top;
  localparam logic [5:0] LD = 6'd0, ST = 6'd1, AL = 6'd2, FR = 6'd3;

  typedef struct packed {
    logic [3:0]  vld;
    logic [63:0] addr;
    logic [23:0] ev;
    logic [3:0]  hit;
    logic [15:0] cst;
    logic [2:0]  cnum;
    logic        eRdy, eMiss, eFull, eExc;
    logic [1:0]  eLane;
    logic [15:0] eCur;
    logic [3:0]  eWr;
    logic [15:0] eWa;
    logic [3:0]  eWs;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'b0000, 64'h0, {LD,LD,LD,LD}, 4'b0000, 16'h0, 3'd4, 1'b1,1'b0,1'b0,1'b0, 2'd0, 16'h0, 4'b0000, 16'h0, 4'd0},
    '{4'b0111, {16'h0,16'h12,16'h11,16'h10}, {LD,AL,AL,AL}, 4'b0111, 16'h0111, 3'd0, 1'b1,1'b0,1'b0,1'b0, 2'd0, 16'h0111, 4'b0000, 16'h0, 4'd0},
    '{4'b1111, {16'h11,16'h10,16'h20,16'h10}, {LD,ST,LD,ST}, 4'b1110, 16'h1130, 3'd0, 1'b1,1'b0,1'b0,1'b1, 2'd3, 16'h2332, 4'b0000, 16'h0, 4'd0},
    '{4'b0001, {16'h0,16'h0,16'h0,16'h10}, {LD,LD,LD,LD}, 4'b0001, 16'h0002, 3'd2, 1'b1,1'b0,1'b0,1'b0, 2'd0, 16'h0003, 4'b0011, 16'h10, 4'd2},
    '{4'b0011, {16'h0,16'h0,16'h31,16'h30}, {LD,LD,LD,LD}, 4'b0001, 16'h0003, 3'd1, 1'b0,1'b1,1'b0,1'b0, 2'd0, 16'h0, 4'b0001, 16'h12, 4'd2},
    '{4'b0011, {16'h0,16'h0,16'h31,16'h30}, {LD,LD,LD,LD}, 4'b0011, 16'h0003, 3'd0, 1'b1,1'b0,1'b0,1'b0, 2'd0, 16'h0003, 4'b0000, 16'h0, 4'd0},
    '{4'b1111, {16'h43,16'h42,16'h41,16'h40}, {AL,AL,AL,AL}, 4'b1111, 16'h1111, 3'd0, 1'b1,1'b0,1'b0,1'b0, 2'd0, 16'h1111, 4'b0000, 16'h0, 4'd0},
    '{4'b1111, {16'h53,16'h52,16'h51,16'h50}, {AL,AL,AL,AL}, 4'b1111, 16'h1111, 3'd0, 1'b0,1'b0,1'b1,1'b0, 2'd0, 16'h0, 4'b0000, 16'h0, 4'd0},
    '{4'b0111, {16'h53,16'h52,16'h51,16'h50}, {AL,AL,AL,AL}, 4'b1111, 16'h1111, 3'd0, 1'b1,1'b0,1'b0,1'b0, 2'd0, 16'h0111, 4'b0000, 16'h0, 4'd0},
    '{4'b0001, {16'h0,16'h0,16'h0,16'h60}, {LD,LD,LD,LD}, 4'b0001, 16'h0003, 3'd4, 1'b1,1'b0,1'b0,1'b0, 2'd0, 16'h0003, 4'b1111, 16'h10, 4'd3},
    '{4'b0101, {16'h0,16'h43,16'h70,16'h43}, {LD,ST,AL,ST}, 4'b0111, 16'h0101, 3'd0, 1'b1,1'b0,1'b0,1'b0, 2'd0, 16'h0302, 4'b0000, 16'h0, 4'd0},
    '{4'b0011, {16'h0,16'h0,16'h81,16'h80}, {LD,LD,AL,FR}, 4'b0011, 16'h0010, 3'd0, 1'b1,1'b0,1'b0,1'b1, 2'd0, 16'h0010, 4'b0000, 16'h0, 4'd0},
    '{4'b0001, {16'h0,16'h0,16'h0,16'h81}, {LD,LD,LD,LD}, 4'b0000, 16'h0, 3'd7, 1'b0,1'b1,1'b0,1'b0, 2'd0, 16'h0, 4'b1111, 16'h43, 4'd2},
    '{4'b0000, 64'h0, {LD,LD,LD,LD}, 4'b0000, 16'h0, 3'd4, 1'b1,1'b0,1'b0,1'b0, 2'd0, 16'h0, 4'b0001, 16'h43, 4'd3},
    '{4'b0000, 64'h0, {LD,LD,LD,LD}, 4'b0000, 16'h0, 3'd4, 1'b1,1'b0,1'b0,1'b0, 2'd0, 16'h0, 4'b0000, 16'h0, 4'd0}
  };

  function automatic string tagOf(int i);
    case (i)
      0: return "R1";
      1: return "R2 R8";
      2: return "R4 R6 R7";
      3: return "R5 R9";
      4: return "R3";
      5: return "R3 R2";
      6: return "R8";
      7: return "R10";
      8: return "R10 R11";
      9: return "R10 R9";
      10: return "R11 R6";
      11: return "R7";
      12: return "R7 R9";
      13: return "R9";
      default: return "R9 R1";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  laneValid;
  logic [63:0] laneAddr;
  logic [23:0] laneEvent;
  logic [3:0]  cacheHit;
  logic [15:0] cacheState;
  logic [15:0] tblCurState;
  logic [23:0] tblEvent;
  logic [15:0] tblNextState;
  logic [3:0]  tblExc;
  logic        grpReady, stallMiss, stallFull, excValid;
  logic [1:0]  excLane;
  logic [2:0]  commitNum;
  logic [3:0]  wrValid;
  logic [63:0] wrAddr;
  logic [15:0] wrState;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  // Heap-tracking rule set: 0 outside heap, 1 unallocated, 2 uninitialised, 3 initialised.
  function automatic logic [4:0] heapRule(logic [3:0] s, logic [5:0] e);
    case (s)
      4'd0: return (e == AL || e == FR) ? {1'b1, 4'd0} : {1'b0, 4'd0};
      4'd1: return (e == AL) ? {1'b0, 4'd2} : {1'b1, 4'd1};
      4'd2: return (e == ST) ? {1'b0, 4'd3} : (e == FR) ? {1'b0, 4'd1} : {1'b1, 4'd2};
      4'd3: return (e == LD || e == ST) ? {1'b0, 4'd3} : (e == FR) ? {1'b0, 4'd1} : {1'b1, 4'd3};
      default: return {1'b0, s};
    endcase
  endfunction

  for (genvar g = 0; g < 4; g++) begin : g_tbl
    logic [4:0] r;
    assign r = heapRule(tblCurState[g*4 +: 4], tblEvent[g*6 +: 6]);
    assign tblNextState[g*4 +: 4] = r[3:0];
    assign tblExc[g] = r[4];
  end

  stchk_unit dut_i (
    .clk, .rstN, .laneValid, .laneAddr, .laneEvent, .cacheHit, .cacheState,
    .tblCurState, .tblEvent, .tblNextState, .tblExc, .grpReady, .stallMiss,
    .stallFull, .excValid, .excLane, .commitNum, .wrValid, .wrAddr, .wrState
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    @(negedge clk);
    laneValid  = v.vld;
    laneAddr   = v.addr;
    laneEvent  = v.ev;
    cacheHit   = v.hit;
    cacheState = v.cst;
    commitNum  = v.cnum;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    laneValid = '0; laneAddr = '0; laneEvent = '0;
    cacheHit = '0; cacheState = '0; commitNum = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    vec_t d;
    rstN = 1'b0;
    idle();
    idle();
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string t;
      v = VECS[i];
      t = tagOf(i);
      drive(v);
      check(t, "grpReady", 64'(grpReady), 64'(v.eRdy));
      check(t, "stallMiss", 64'(stallMiss), 64'(v.eMiss));
      check(t, "stallFull", 64'(stallFull), 64'(v.eFull));
      check(t, "excValid", 64'(excValid), 64'(v.eExc));
      if (v.eExc) check(t, "excLane", 64'(excLane), 64'(v.eLane));
      if (v.eRdy) begin
        for (int l = 0; l < 4; l++) begin
          if (v.vld[l]) check(t, $sformatf("curState lane%0d", l),
                              64'(tblCurState[l*4 +: 4]), 64'(v.eCur[l*4 +: 4]));
        end
      end
      check(t, "wrValid", 64'(wrValid), 64'(v.eWr));
      if (v.eWr[0]) begin
        check(t, "wrAddr slot0", 64'(wrAddr[15:0]), 64'(v.eWa));
        check(t, "wrState slot0", 64'(wrState[3:0]), 64'(v.eWs));
      end
    end

    // R1: reset drops queued updates; they neither forward nor get written.
    d = '0;
    d.vld = 4'b0001; d.addr = 64'h90; d.ev = {LD,LD,LD,AL}; d.hit = 4'b0001; d.cst = 16'h0001;
    drive(d);
    check("R1", "alloc accepted", 64'(grpReady), 64'd1);
    @(negedge clk);
    rstN = 1'b0;
    laneValid = '0;
    @(negedge clk);
    rstN = 1'b1;
    d = '0;
    d.vld = 4'b0001; d.addr = 64'h90; d.ev = {LD,LD,LD,LD}; d.hit = 4'b0000; d.cnum = 3'd4;
    drive(d);
    check("R1", "wrValid after reset", 64'(wrValid), 64'd0);
    check("R1", "no forward after reset", 64'(stallMiss), 64'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule